// File: doc/BRIEF.md
# Sector Hamming Syndrome Corrector

This block decides what to do with one 512-byte sector after a read. It takes two 24-bit check codes: the code kept in the spare area and the code recomputed over the data just read. It spreads each code into a 32-bit word and XORs the two words into a syndrome. It classifies the syndrome by its bit count. One cycle after a start strobe it presents a registered verdict. For a single-bit data error, the verdict carries the byte index and bit position that must be flipped.

A read-modify-write port can be included with a parameter. When the verdict is "fixed", this port reads the addressed byte from the sector buffer, inverts the faulty bit and writes the byte back, with no help from software. An erased sector has an all-ones stored code and an all-zeros computed code. The block treats such a sector as clean and does not report it as a failure.

Top module: `sector_hamming_fixer`

## Requirements
- R1: Each code is spread into a 32-bit word as follows. Code bits [7:0] go to word bits [7:0]. Code bits [15:8] go to word bits [23:16]. Code bits [19:16] go to word bits [11:8]. Code bits [23:20] go to word bits [27:24]. All other word bits are zero. The syndrome is the XOR of the spread stored word and the spread computed word.
- R2: A zero syndrome gives status 0 (clean).
- R3: A syndrome with exactly 12 set bits gives status 1 (fixed). In that case fix_bit = syndrome[18:16] and fix_byte = syndrome[27:19]. For every other status, fix_byte and fix_bit are 0.
- R4: A syndrome with exactly 1 set bit gives status 2 (code corrupted).
- R5: Any other non-zero syndrome gives status 3 (uncorrectable), except in the case covered by R6.
- R6: A spread stored word of 0x0FFF0FFF together with a computed code of zero gives status 0.
- R7: done is high in exactly the cycle after a cycle in which start is high, and low otherwise. The status, fix_byte and fix_bit outputs change only on a start and hold their values until the next start.
- R8: For status 1, the buffer port performs these steps in order. (1) The cycle after done, it raises buf_rd_en for one cycle with buf_addr = fix_byte. (2) Two cycles later, it raises buf_wr_en for one cycle with the same address, and buf_wdata equals the read byte XOR (1 << fix_bit). The buffer returns read data one cycle after buf_rd_en.
- R9: For statuses 0, 2 and 3, there is no buffer read and no buffer write, so the buffer contents stay unchanged.
- R10: While in reset, done, status, fix_byte, fix_bit, buf_rd_en and buf_wr_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate the codes presented this cycle |
| code_stored | input | 24 | Check code read from the spare area |
| code_calc | input | 24 | Check code recomputed over the data |
| done | output | 1 | Verdict valid pulse |
| status | output | 2 | 0 clean, 1 fixed, 2 code corrupted, 3 uncorrectable |
| fix_byte | output | 9 | Byte index of the faulty bit |
| fix_bit | output | 3 | Bit position within that byte |
| buf_rd_en | output | 1 | Sector buffer read strobe |
| buf_wr_en | output | 1 | Sector buffer write strobe |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_wdata | output | 8 | Corrected byte to write back |
| buf_rdata | input | 8 | Byte returned one cycle after a read |

## Verification
The main function is tried with five kinds of code pairs:
- matching codes, which must be reported clean;
- one flipped data bit at several positions, including the first and last bit of the sector, which must be reported fixed, and which also checks the spreading layout and the address fields;
- one flipped bit in the stored code, including both ends of the code, which must be reported as a corrupted code;
- two flipped data bits, which must be reported uncorrectable;
- the all-ones and all-zeros code pair of an erased sector, and codes that miss that pattern by one bit, which separate the erased-sector rule from the uncorrectable path.

After each case the bench checks its own model of the buffer. A fixed verdict must change exactly one bit. Every other verdict must leave the buffer unchanged.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    typedef enum logic [1:0] {
        HSC_CLEAN    = 2'd0,
        HSC_FIXED    = 2'd1,
        HSC_CODE_BAD = 2'd2,
        HSC_FATAL    = 2'd3
    } hsc_status_e;

    localparam int CODE_W   = 24;
    localparam int WORD_W   = 32;
    localparam int BIT_W    = 3;
    localparam int HALF_OFS = 16;
    localparam logic [WORD_W-1:0] ERASED_WORD = 32'h0FFF_0FFF;

endpackage

// File: rtl/hsc_unpack.sv
module hsc_unpack
    import hsc_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [WORD_W-1:0] word_o
);
    // Low byte and middle byte land in the two halves; the top byte is
    // split into nibbles that sit just above each half.
    always_comb begin
        word_o        = '0;
        word_o[7:0]   = code_i[7:0];
        word_o[23:16] = code_i[15:8];
        word_o[11:8]  = code_i[19:16];
        word_o[27:24] = code_i[23:20];
    end
endmodule

// File: rtl/hsc_classify.sv
module hsc_classify
    import hsc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    localparam int BYTE_W     = $clog2(SECTOR_BYTES),
    localparam int FIX_WEIGHT = $clog2(SECTOR_BYTES * 8),
    localparam int CNT_W      = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] stored_w_i,
    input  logic [WORD_W-1:0] calc_w_i,
    output hsc_status_e       status_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [BIT_W-1:0]  bit_o
);
    logic [WORD_W-1:0] syn;
    logic [CNT_W-1:0]  weight;
    logic              erased;

    assign syn    = stored_w_i ^ calc_w_i;
    assign erased = (stored_w_i == ERASED_WORD) && (calc_w_i == '0);

    always_comb begin
        weight = '0;
        for (int i = 0; i < WORD_W; i++) begin
            weight = weight + CNT_W'(syn[i]);
        end
    end

    always_comb begin
        status_o = HSC_FATAL;
        byte_o   = '0;
        bit_o    = '0;
        if (syn == '0) begin
            status_o = HSC_CLEAN;
        end else if (weight == CNT_W'(FIX_WEIGHT)) begin
            status_o = HSC_FIXED;
            bit_o    = syn[HALF_OFS +: BIT_W];
            byte_o   = syn[HALF_OFS + BIT_W +: BYTE_W];
        end else if (weight == CNT_W'(1)) begin
            status_o = HSC_CODE_BAD;
        end else if (erased) begin
            status_o = HSC_CLEAN;
        end
    end
endmodule

// File: rtl/hsc_patch.sv
module hsc_patch
    import hsc_pkg::*;
#(
    parameter int  BYTE_W = 9,
    parameter bit  ENABLE = 1'b1,
    localparam int DATA_W = 1 << BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BIT_W-1:0]  bit_i,
    output logic              rd_en_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    input  logic [DATA_W-1:0] rdata_i
);
    typedef enum logic [1:0] {PT_IDLE, PT_READ, PT_HOLD, PT_WRITE} pt_state_e;

    typedef struct packed {
        pt_state_e         state;
        logic [BYTE_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] wdata;
        logic              rd;
        logic              wr;
    } pt_t;

    generate
        if (ENABLE) begin : g_rmw
            pt_t pt_d, pt_q;

            always_comb begin
                pt_d    = pt_q;
                pt_d.rd = 1'b0;
                pt_d.wr = 1'b0;
                unique case (pt_q.state)
                    PT_IDLE: begin
                        if (go_i) begin
                            pt_d.state = PT_READ;
                            pt_d.addr  = byte_i;
                            pt_d.mask  = DATA_W'(1) << bit_i;
                            pt_d.rd    = 1'b1;
                        end
                    end
                    PT_READ: pt_d.state = PT_HOLD;
                    PT_HOLD: begin
                        pt_d.state = PT_WRITE;
                        pt_d.wdata = rdata_i ^ pt_q.mask;
                        pt_d.wr    = 1'b1;
                    end
                    default: pt_d.state = PT_IDLE;
                endcase
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pt_q <= '{state: PT_IDLE, default: '0};
                end else begin
                    pt_q <= pt_d;
                end
            end

            assign rd_en_o = pt_q.rd;
            assign wr_en_o = pt_q.wr;
            assign addr_o  = pt_q.addr;
            assign wdata_o = pt_q.wdata;

            // R8: a read is always followed two cycles later by the write
            p_write_follows_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
                rd_en_o |-> ##2 (wr_en_o && addr_o == $past(addr_o, 2)));
            p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !(rd_en_o && wr_en_o));
        end else begin : g_none
            assign rd_en_o = 1'b0;
            assign wr_en_o = 1'b0;
            assign addr_o  = '0;
            assign wdata_o = '0;
        end
    endgenerate
endmodule

// File: rtl/sector_hamming_fixer.sv
module sector_hamming_fixer
    import hsc_pkg::*;
#(
    parameter int  SECTOR_BYTES = 512,
    parameter bit  FIX_PORT_EN  = 1'b1,
    localparam int BYTE_W       = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [23:0]       code_stored,
    input  logic [23:0]       code_calc,
    output logic              done,
    output logic [1:0]        status,
    output logic [BYTE_W-1:0] fix_byte,
    output logic [2:0]        fix_bit,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [BYTE_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    logic [WORD_W-1:0] stored_w, calc_w;
    hsc_status_e       cls_status;
    logic [BYTE_W-1:0] cls_byte;
    logic [BIT_W-1:0]  cls_bit;

    hsc_unpack u_unpack_stored (.code_i(code_stored), .word_o(stored_w));
    hsc_unpack u_unpack_calc   (.code_i(code_calc),   .word_o(calc_w));

    hsc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_classify (
        .stored_w_i (stored_w),
        .calc_w_i   (calc_w),
        .status_o   (cls_status),
        .byte_o     (cls_byte),
        .bit_o      (cls_bit)
    );

    typedef struct packed {
        logic              done;
        hsc_status_e       status;
        logic [BYTE_W-1:0] byte_idx;
        logic [BIT_W-1:0]  bit_pos;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d      = res_q;
        res_d.done = start;
        if (start) begin
            res_d.status   = cls_status;
            res_d.byte_idx = cls_byte;
            res_d.bit_pos  = cls_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '{status: HSC_CLEAN, default: '0};
        end else begin
            res_q <= res_d;
        end
    end

    assign done     = res_q.done;
    assign status   = res_q.status;
    assign fix_byte = res_q.byte_idx;
    assign fix_bit  = res_q.bit_pos;

    hsc_patch #(.BYTE_W(BYTE_W), .ENABLE(FIX_PORT_EN)) u_patch (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (res_q.done && res_q.status == HSC_FIXED),
        .byte_i  (res_q.byte_idx),
        .bit_i   (res_q.bit_pos),
        .rd_en_o (buf_rd_en),
        .wr_en_o (buf_wr_en),
        .addr_o  (buf_addr),
        .wdata_o (buf_wdata),
        .rdata_i (buf_rdata)
    );

    p_done_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    p_verdict_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(status) && $stable(fix_byte) && $stable(fix_bit)));
    p_addr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd1) |-> (fix_byte == '0 && fix_bit == '0));
    p_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd1) |=> !buf_rd_en);
endmodule

// File: tb/test_sector_hamming_fixer.sv
module test_sector_hamming_fixer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] code_stored = '0, code_calc = '0;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  fix_byte, buf_addr;
    logic [2:0]  fix_bit;
    logic        buf_rd_en, buf_wr_en;
    logic [7:0]  buf_wdata, buf_rdata;

    int n_checks = 0, n_fails = 0, n_rd = 0, n_wr = 0;
    logic [7:0] mem [512];

    always #10ns clk = ~clk;

    sector_hamming_fixer i_sector_hamming_fixer (
        .clk(clk), .rst_n(rst_n), .start(start),
        .code_stored(code_stored), .code_calc(code_calc),
        .done(done), .status(status), .fix_byte(fix_byte), .fix_bit(fix_bit),
        .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    // sector buffer model with one-cycle read latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 37 + 11);
            buf_rdata <= '0;
            n_rd <= 0;
            n_wr <= 0;
        end else begin
            if (buf_rd_en) begin
                buf_rdata <= mem[buf_addr];
                n_rd <= n_rd + 1;
            end
            if (buf_wr_en) begin
                mem[buf_addr] <= buf_wdata;
                n_wr <= n_wr + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // packed code difference produced by one flipped data bit at position p
    function automatic logic [23:0] flip_code(input logic [11:0] p);
        return {p[11:8], ~p[11:8], p[7:0], ~p[7:0]};
    endfunction

    typedef struct packed {
        logic [2:0]  mode;   // 0 none,1 data bit,2 code bit,3 two data bits,4 raw xor
        logic [23:0] arg;
        logic [23:0] calc;
        logic [1:0]  st;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 24'h000000, 24'h123456, 2'd0},
        '{3'd0, 24'h000000, 24'h000000, 2'd0},
        '{3'd1, 24'h000000, 24'h3C5A96, 2'd1},
        '{3'd1, 24'h000FFF, 24'h0F0F0F, 2'd1},
        '{3'd1, 24'h0002A5, 24'hABCDEF, 2'd1},
        '{3'd1, 24'h000801, 24'h00FF00, 2'd1},
        '{3'd2, 24'h000000, 24'h55AA55, 2'd2},
        '{3'd2, 24'h000017, 24'h111111, 2'd2},
        '{3'd2, 24'h00000C, 24'h000000, 2'd2},
        '{3'd3, 24'h000001, 24'h777777, 2'd3},
        '{3'd3, 24'h000FFF, 24'h246801, 2'd3},
        '{3'd4, 24'hFFFFFF, 24'h000000, 2'd0},
        '{3'd4, 24'hFFFFFE, 24'h000001, 2'd3},
        '{3'd4, 24'hFFFFFE, 24'h000000, 2'd3},
        '{3'd4, 24'h000300, 24'h000000, 2'd3}
    };

    task automatic run_vec(input vec_t v);
        logic [23:0] delta;
        logic [8:0]  eb;
        logic [2:0]  ebit;
        logic [7:0]  old;
        int          rd0, wr0;
        case (v.mode)
            3'd1:    delta = flip_code(v.arg[11:0]);
            3'd2:    delta = 24'(1) << v.arg[4:0];
            3'd3:    delta = flip_code(12'h000) ^ flip_code(v.arg[11:0]);
            3'd4:    delta = v.arg;
            default: delta = '0;
        endcase
        eb   = (v.mode == 3'd1) ? v.arg[11:3] : 9'd0;
        ebit = (v.mode == 3'd1) ? v.arg[2:0]  : 3'd0;
        old  = mem[eb];
        rd0  = n_rd;
        wr0  = n_wr;
        @(negedge clk);
        code_calc   = v.calc;
        code_stored = v.calc ^ delta;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2 R3 R4 R5 R6 status; R1 spreading seen through the address fields
        check(done == 1'b1, "R7 done after start", 32'(done), 32'd1);
        check(status == v.st, "R2/R3/R4/R5/R6 status", 32'(status), 32'(v.st));
        check(fix_byte == eb, "R1 R3 fix_byte", 32'(fix_byte), 32'(eb));
        check(fix_bit == ebit, "R1 R3 fix_bit", 32'(fix_bit), 32'(ebit));
        @(negedge clk);
        check(done == 1'b0, "R7 done single cycle", 32'(done), 32'd0);
        repeat (5) @(negedge clk);
        check(status == v.st, "R7 status held", 32'(status), 32'(v.st));
        if (v.st == 2'd1) begin
            check(n_rd == rd0 + 1 && n_wr == wr0 + 1, "R8 one read one write",
                  32'(n_rd - rd0), 32'd1);
            check(mem[eb] == (old ^ (8'd1 << ebit)), "R8 bit flipped in buffer",
                  32'(mem[eb]), 32'(old ^ (8'd1 << ebit)));
        end else begin
            check(n_rd == rd0 && n_wr == wr0, "R9 no buffer access",
                  32'(n_rd - rd0 + n_wr - wr0), 32'd0);
            check(mem[eb] == old, "R9 buffer unchanged", 32'(mem[eb]), 32'(old));
        end
    endtask

    initial begin
        #(20ns * 200000);
        n_fails++;
        $display("FAIL watchdog: got %0h expected %0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state (start high during reset must have no effect)
        start = 1'b1;
        @(negedge clk);
        check(done == 0 && status == 0, "R10 reset done/status", {done, status}, 0);
        check(fix_byte == 0 && fix_bit == 0, "R10 reset address", {fix_byte, fix_bit}, 0);
        check(!buf_rd_en && !buf_wr_en, "R10 reset strobes", {buf_rd_en, buf_wr_en}, 0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 0, "R10 no done after reset", 32'(done), 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R7 back-to-back starts: fixed then code error
        @(negedge clk);
        code_calc = 24'h0; code_stored = flip_code(12'h123); start = 1'b1;
        @(negedge clk);
        check(done && status == 2'd1, "R7 first back-to-back", {done, status}, 32'h5);
        code_stored = 24'h000040;
        @(negedge clk);
        start = 1'b0;
        check(done && status == 2'd2, "R7 second back-to-back", {done, status}, 32'h6);
        check(fix_byte == 0, "R3 address cleared after non-fixed", 32'(fix_byte), 0);
        @(negedge clk);
        check(!done, "R7 done drops", 32'(done), 0);
        repeat (6) @(negedge clk);

        // R7 inputs changing without start leave the verdict alone
        code_stored = 24'hFFFFFF; code_calc = 24'h0;
        repeat (2) @(negedge clk);
        check(status == 2'd2 && !done, "R7 no start no change", {done, status}, 32'h2);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule